// File: doc/BRIEF.md
# Upset-Tolerant Four-Phase Control Sequencer

This block is a small control sequencer for a critical datapath. It walks through a four-phase work cycle: idle, run, wait and done. A start request moves it out of idle. After one cycle in run it moves to wait. An acknowledge moves it from wait to done, and it then drops back to idle by itself. The phase is held in a one-hot register. Every pair of legal codes therefore differs in two bits, and a single flipped bit always gives a code the decoder recognises as illegal.

The next value is defined for all sixteen patterns the four state flip-flops can hold, not only for the four legal ones. Any pattern whose population count is not exactly one is sent back to idle on the next clock and raises a sticky error flag, so no pattern can trap the machine.

The state flip-flops have no reset pin. Instead, an asynchronous power-on reset is brought into the clock domain by a short synchronizer. Its output acts as a hold gate on the next-state logic: while the gate is high, idle is loaded on every clock and the request inputs are ignored. The raw state register is driven onto debug outputs. A test load port can write any pattern into the register so that upsets can be emulated.

Top module: `ft_onehot_seq`

## Requirements
- R1: The state is held one-hot, with idle = 4'b0001, run = 4'b0010, wait = 4'b0100 and done = 4'b1000. `dbg_state` always shows the raw register contents.
- R2: In idle, the machine moves to run on a clock where `start` is high. Otherwise it stays in idle.
- R3: Run lasts exactly one cycle and always moves to wait.
- R4: Wait moves to done on a clock where `ack` is high and otherwise stays in wait. Done always returns to idle on the next clock.
- R5: `busy` is high exactly when the register holds the run or wait code. `done` is high exactly when it holds the done code. Both are low for any illegal pattern.
- R6: A register pattern whose population count is not one (all-zero or multi-hot) loads idle on the next clock and sets `err_flag`.
- R7: `err_flag` stays set until a clock where `err_clr` is high and the register holds a legal code. Detection of an illegal code wins over a clear in the same cycle.
- R8: `hold` goes high at once when `por_n` falls. It stays high until the second rising clock edge after `por_n` rises.
- R9: While `hold` is high, every clock loads idle and clears `err_flag`, and `start`, `ack` and the test load port have no effect.
- R10: When `hold` is low and the current code is legal, a clock with `tl_en` high loads `tl_state` into the register in place of the normal transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| start | input | 1 | Request to begin a work cycle |
| ack | input | 1 | Acknowledge that ends the wait phase |
| err_clr | input | 1 | Clears the sticky error flag |
| tl_en | input | 1 | Test load enable for upset emulation |
| tl_state | input | 4 | Pattern written by the test load |
| busy | output | 1 | High in the run or wait phase |
| done | output | 1 | High in the done phase |
| err_flag | output | 1 | Sticky illegal-code indication |
| hold | output | 1 | Synchronized reset gate |
| dbg_state | output | 4 | Raw state register for debug |

## Verification
Random start, ack and clear traffic exercises the legal cycle. It shows whether each phase waits for its own input and ignores the others. Every one of the sixteen patterns is written through the test load port, including all-zero, single-, double-, triple- and all-hot codes. This separates the four legal codes, which follow the normal cycle, from the twelve illegal ones, which must return to idle with the flag set. Dropping `por_n` mid-cycle while start, ack and a test load are active shows that the hold gate asserts at once, overrides every input, and releases after exactly two edges. A clear issued together with an illegal code checks the priority between the two.

// File: rtl/ft_seq_pkg.sv
package ft_seq_pkg;
    localparam int NUM_PHASES = 4;
    localparam int POP_W      = $clog2(NUM_PHASES + 1);

    typedef logic [NUM_PHASES-1:0] phase_vec_t;

    localparam phase_vec_t PH_IDLE = 4'b0001;
    localparam phase_vec_t PH_RUN  = 4'b0010;
    localparam phase_vec_t PH_WAIT = 4'b0100;
    localparam phase_vec_t PH_DONE = 4'b1000;

    typedef struct packed {
        phase_vec_t phase;
        logic       err;
    } seq_regs_t;
endpackage

// File: rtl/ft_por_sync.sv
module ft_por_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    output logic hold
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign hold = ~chain_q[LAST];
endmodule

// File: rtl/ft_onehot_check.sv
module ft_onehot_check
    import ft_seq_pkg::*;
(
    input  phase_vec_t       vec,
    output logic [POP_W-1:0] pop,
    output logic             illegal
);
    always_comb begin
        pop = '0;
        for (int i = 0; i < NUM_PHASES; i++) begin
            pop = pop + POP_W'(vec[i]);
        end
        illegal = (pop != POP_W'(1));
    end
endmodule

// File: rtl/ft_onehot_seq.sv
module ft_onehot_seq
    import ft_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  start,
    input  logic                  ack,
    input  logic                  err_clr,
    input  logic                  tl_en,
    input  logic [NUM_PHASES-1:0] tl_state,
    output logic                  busy,
    output logic                  done,
    output logic                  err_flag,
    output logic                  hold,
    output logic [NUM_PHASES-1:0] dbg_state
);
    seq_regs_t         regs_d, regs_q;
    logic [POP_W-1:0]  pop_cnt;
    logic              illegal;

    ft_por_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .hold  (hold)
    );

    ft_onehot_check u_check (
        .vec     (regs_q.phase),
        .pop     (pop_cnt),
        .illegal (illegal)
    );

    // Next value for every physical pattern; hold gates all inputs.
    always_comb begin
        regs_d = regs_q;
        if (hold) begin
            regs_d.phase = PH_IDLE;
            regs_d.err   = 1'b0;
        end else if (illegal) begin
            regs_d.phase = PH_IDLE;
            regs_d.err   = 1'b1;
        end else begin
            regs_d.err = regs_q.err & ~err_clr;
            if (tl_en) begin
                regs_d.phase = tl_state;
            end else begin
                case (regs_q.phase)
                    PH_IDLE: regs_d.phase = start ? PH_RUN : PH_IDLE;
                    PH_RUN:  regs_d.phase = PH_WAIT;
                    PH_WAIT: regs_d.phase = ack ? PH_DONE : PH_WAIT;
                    PH_DONE: regs_d.phase = PH_IDLE;
                    default: regs_d.phase = PH_IDLE;
                endcase
            end
        end
    end

    // No reset pin on the state flops: the synchronized gate drives them.
    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign busy      = (regs_q.phase == PH_RUN) || (regs_q.phase == PH_WAIT);
    assign done      = (regs_q.phase == PH_DONE);
    assign err_flag  = regs_q.err;
    assign dbg_state = regs_q.phase;

    // R6: any illegal code recovers to idle with the flag raised
    assert_illegal_recover_R6: assert property (@(posedge clk) disable iff (!por_n)
        (!hold && illegal) |=> (dbg_state == PH_IDLE && err_flag));

    // R3: run is a single cycle
    assert_run_to_wait_R3: assert property (@(posedge clk) disable iff (!por_n)
        (!hold && !tl_en && dbg_state == PH_RUN) |=> (dbg_state == PH_WAIT));

    // R4: done always returns to idle
    assert_done_to_idle_R4: assert property (@(posedge clk) disable iff (!por_n)
        (!hold && !tl_en && dbg_state == PH_DONE) |=> (dbg_state == PH_IDLE));

    // R7: flag is sticky without a clear
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
        (!hold && err_flag && !err_clr) |=> err_flag);

    // R9: gate forces idle and clears the flag
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!por_n)
        hold |=> (dbg_state == PH_IDLE && !err_flag));

    // R5: busy and done never both high
    assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({busy, done}));
endmodule

// File: tb/tb_ft_onehot_seq.sv
module tb_ft_onehot_seq;
    localparam time CLK_PERIOD = 10ns;
    localparam int  RAND_STEPS = 4000;

    logic       clk = 1'b0;
    logic       por_n, start, ack, err_clr, tl_en;
    logic [3:0] tl_state;
    logic       busy, done, err_flag, hold;
    logic [3:0] dbg_state;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [3:0] m_state;
    logic       m_err;
    int         m_cnt;
    bit         m_known;

    localparam logic [3:0] S_IDLE = 4'b0001, S_RUN = 4'b0010,
                           S_WAIT = 4'b0100, S_DONE = 4'b1000;

    always #(CLK_PERIOD/2) clk = ~clk;

    ft_onehot_seq dut (
        .clk(clk), .por_n(por_n), .start(start), .ack(ack), .err_clr(err_clr),
        .tl_en(tl_en), .tl_state(tl_state), .busy(busy), .done(done),
        .err_flag(err_flag), .hold(hold), .dbg_state(dbg_state)
    );

    function automatic bit legal(input logic [3:0] s);
        return $countones(s) == 1;
    endfunction

    function automatic logic [3:0] next_phase(input logic [3:0] s, input logic st,
                                              input logic ak);
        case (s)
            S_IDLE:  return st ? S_RUN : S_IDLE;
            S_RUN:   return S_WAIT;
            S_WAIT:  return ak ? S_DONE : S_WAIT;
            default: return S_IDLE;
        endcase
    endfunction

    function automatic bit m_hold();
        return !por_n || m_cnt < 2;
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R8 hold", {3'b0, hold}, {3'b0, m_hold()});
        if (m_known) begin
            chk("R1 dbg_state", dbg_state, m_state);
            chk("R7 err_flag", {3'b0, err_flag}, {3'b0, m_err});
            chk("R5 busy", {3'b0, busy}, {3'b0, (m_state == S_RUN || m_state == S_WAIT)});
            chk("R5 done", {3'b0, done}, {3'b0, (m_state == S_DONE)});
        end
    endtask

    // One clock: drive after negedge, update model at posedge, check at negedge.
    task automatic step(input logic st, input logic ak, input logic clr,
                        input logic le, input logic [3:0] lv);
        start = st; ack = ak; err_clr = clr; tl_en = le; tl_state = lv;
        @(posedge clk);
        if (m_hold()) begin
            m_state = S_IDLE; m_err = 1'b0; m_known = 1;
        end else if (!legal(m_state)) begin
            m_state = S_IDLE; m_err = 1'b1;
        end else begin
            m_err   = m_err & ~clr;
            m_state = le ? lv : next_phase(m_state, st, ak);
        end
        if (por_n && m_cnt < 2) m_cnt++;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        void'($urandom(32'h1c0ffee5));
        por_n = 1'b0; start = 0; ack = 0; err_clr = 0; tl_en = 0; tl_state = '0;
        m_cnt = 0; m_known = 0; m_state = S_IDLE; m_err = 0;
        @(negedge clk);
        #1 chk("R8 hold during por", {3'b0, hold}, 4'b0001);
        // R9: inputs ignored while held
        step(1, 1, 0, 1, 4'b1111);
        step(1, 0, 0, 1, 4'b0110);
        por_n = 1'b1;
        step(1, 0, 0, 0, 4'b0000);   // R8 still held after first edge
        step(1, 0, 0, 0, 4'b0000);   // R8 released after second edge
        // R2..R4 directed cycle
        step(0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        // R6 R10: every physical pattern through the test load
        for (int p = 0; p < 16; p++) begin
            step(0, 0, 0, 1, 4'(p));
            step(0, 0, 0, 0, 0);
            step(0, 0, 1, 0, 0);
            step(0, 1, 0, 0, 0);
            step(0, 0, 0, 0, 0);
        end
        // R7: clear together with an illegal code loses
        step(0, 0, 0, 1, 4'b0000);
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        // Random traffic
        for (int i = 0; i < RAND_STEPS; i++) begin
            logic le = ($urandom_range(15) == 0);
            step(1'($urandom_range(1)), 1'($urandom_range(1)),
                 ($urandom_range(7) == 0), le, 4'($urandom_range(15)));
            if (i % 997 == 500) begin
                // R8 R9: asynchronous reset mid-run
                #1 por_n = 1'b0;
                m_cnt = 0;
                #1 chk("R8 async hold", {3'b0, hold}, 4'b0001);
                step(1, 1, 1, 1, 4'b1011);
                step(1, 1, 0, 1, 4'b0100);
                por_n = 1'b1;
                step(1, 0, 0, 1, 4'b0010);
                step(1, 0, 0, 0, 0);
            end
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule